// File: doc/BRIEF.md
# Precharge-Evaluate Cycle Sequencer

This block is a synchronous controller that produces the repeating control waveform for a precharged, wave-based processing array. One clock period is one tick; at a 50 MHz clock a tick is 20 ns. While its run input is high, the block steps through five timed phases. The first is a one-tick initialize marker. The second is a precharge pulse. The third is a quiet settling gap that gives the supply time to recover. The fourth is an active-low evaluation phase, during which a one-tick capture strobe latches the array result. The fifth is a programmable run of trailing wait ticks. Then the cycle starts over.

Two values are sampled once per cycle, at the moment the cycle begins: the trailing wait count and the capture offset. Changing either input during a cycle therefore has no effect until the next cycle. When run is dropped, the cycle in progress runs to its end and the outputs then rest at their idle levels. The states are STOPPED, INIT, PRECHARGE, SETTLE, EVALUATE and WAIT. The transitions are:
- STOPPED→INIT when run is high.
- INIT→PRECHARGE, PRECHARGE→SETTLE, SETTLE→EVALUATE and EVALUATE→WAIT when each phase's tick count expires.
- WAIT→INIT when the last wait tick ends and run is high.
- WAIT→STOPPED when the last wait tick ends and run is low.

Top module: `pe_cycle_seq`

## Requirements
- R1: While reset is asserted, and after reset until run is first raised, the outputs are idle: init_o=0, precharge_o=0, start_n_o=1, capture_o=0, cycle_done_o=0.
- R2: Every cycle opens with exactly one tick in which init_o=1 and every other output is idle. From STOPPED, that tick is the tick after the first clock edge that sees run_i high.
- R3: Right after the init tick, precharge_o is 1 for exactly 4 ticks, with start_n_o held at 1.
- R4: After precharge falls, there are exactly 8 ticks in which all outputs are idle, before start_n_o falls.
- R5: start_n_o is 0 for exactly 4 consecutive ticks and then returns to 1.
- R6: capture_o is 1 for exactly one tick per cycle, on evaluation tick number S (0 = the first tick with start_n_o low), where S is the sampled capture offset.
- R7: A sampled wait value N (8 bits, 0..255) gives N+1 idle ticks after evaluation. A whole cycle is therefore 18+N ticks, from 360 ns to 5.46 us at a 20 ns tick.
- R8: cycle_done_o is 1 only on the last wait tick of each cycle.
- R9: When run_i is low at the last wait tick, the cycle in progress still completes in full, and from the next tick the outputs stay idle while run_i is low.
- R10: A capture offset above 3 (the 3-bit input ranges over 0..7) is treated as 3, the last evaluation tick.
- R11: The wait count and the capture offset are taken only at the clock edge that enters INIT. Changes made later in that cycle, or while stopped, do not alter the cycle.
- R12: With run_i held high, the init tick of the next cycle directly follows the last wait tick, with no gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tick clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| run_i | input | 1 | High to keep issuing cycles; low to stop after the current one |
| wait_cnt_i | input | 8 | Trailing wait count N, giving N+1 wait ticks |
| cap_sel_i | input | 3 | Evaluation tick on which the capture strobe fires; clamped to 3 |
| init_o | output | 1 | High during the initialize tick |
| precharge_o | output | 1 | Precharge pulse |
| start_n_o | output | 1 | Active-low evaluation phase |
| capture_o | output | 1 | One-tick capture strobe inside evaluation |
| cycle_done_o | output | 1 | High on the last wait tick of a cycle |

## Verification
The hardest cases to reach from the ports are the ones where run or the configuration inputs change at a precise tick inside a cycle. Examples are run falling on the very last wait tick, or the wait count being rewritten just after the cycle has sampled it. The stimulus handles these by counting falling clock edges from the start of each cycle. It changes inputs at a chosen tick: mid-settle, on the final wait tick, and a few ticks after INIT. It then compares every tick of output against a queue of expected vectors built from the requirements. A run at the maximum wait count of 255 and capture offsets of 5 and 6 cover the length and clamp extremes.

// File: rtl/pe_seq_pkg.sv
package pe_seq_pkg;

    // Phases of one precharge-evaluate cycle, plus the parked state.
    typedef enum logic [2:0] {
        ST_STOP   = 3'd0,
        ST_INIT   = 3'd1,
        ST_PRE    = 3'd2,
        ST_SETTLE = 3'd3,
        ST_EVAL   = 3'd4,
        ST_WAIT   = 3'd5
    } pe_state_e;

    // Output bundle shared by the decode logic.
    typedef struct packed {
        logic init;
        logic pre;
        logic start_n;
        logic cap;
        logic done;
    } pe_out_t;

endpackage

// File: rtl/pe_phase_timer.sv
// Down-counter that times the current phase. A load sets the tick
// budget minus one; the phase ends when the counter reads zero.
module pe_phase_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             last_o
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= load_val_i;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign cnt_o  = cnt_q;
    assign last_o = (cnt_q == '0);

endmodule

// File: rtl/pe_sel_clamp.sv
// Saturates the capture offset to the last evaluation tick.
module pe_sel_clamp #(
    parameter int IN_W  = 3,
    parameter int OUT_W = 2,
    parameter int LIMIT = 3
) (
    input  logic [IN_W-1:0]  sel_i,
    output logic [OUT_W-1:0] sel_o
);

    localparam logic [IN_W-1:0] LIM_IN = IN_W'(LIMIT);

    generate
        if (IN_W > OUT_W) begin : g_wide
            always_comb begin
                if (sel_i > LIM_IN) sel_o = LIM_IN[OUT_W-1:0];
                else                sel_o = sel_i[OUT_W-1:0];
            end
        end else begin : g_narrow
            always_comb begin
                if (sel_i > LIM_IN) sel_o = OUT_W'(LIM_IN);
                else                sel_o = OUT_W'(sel_i);
            end
        end
    endgenerate

endmodule

// File: rtl/pe_cfg_latch.sv
// Holds the per-cycle configuration, taken when a cycle begins.
module pe_cfg_latch #(
    parameter int WAIT_W = 8,
    parameter int IDX_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take_i,
    input  logic [WAIT_W-1:0] wait_i,
    input  logic [IDX_W-1:0]  idx_i,
    output logic [WAIT_W-1:0] wait_o,
    output logic [IDX_W-1:0]  idx_o
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wait_o <= '0;
            idx_o  <= '0;
        end else if (take_i) begin
            wait_o <= wait_i;
            idx_o  <= idx_i;
        end
    end

endmodule

// File: rtl/pe_cycle_seq.sv
// Precharge-evaluate cycle sequencer: state register, next-state logic,
// and an output decode process.
module pe_cycle_seq
    import pe_seq_pkg::*;
#(
    parameter int INIT_TICKS   = 1,
    parameter int PRE_TICKS    = 4,
    parameter int SETTLE_TICKS = 8,
    parameter int EVAL_TICKS   = 4,
    parameter int WAIT_W       = 8,
    parameter int SEL_W        = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_i,
    input  logic [WAIT_W-1:0] wait_cnt_i,
    input  logic [SEL_W-1:0]  cap_sel_i,
    output logic              init_o,
    output logic              precharge_o,
    output logic              start_n_o,
    output logic              capture_o,
    output logic              cycle_done_o
);

    localparam int CNT_W = WAIT_W;
    localparam int IDX_W = (EVAL_TICKS > 1) ? $clog2(EVAL_TICKS) : 1;
    localparam logic [CNT_W-1:0] INIT_LD   = CNT_W'(INIT_TICKS - 1);
    localparam logic [CNT_W-1:0] PRE_LD    = CNT_W'(PRE_TICKS - 1);
    localparam logic [CNT_W-1:0] SETTLE_LD = CNT_W'(SETTLE_TICKS - 1);
    localparam logic [CNT_W-1:0] EVAL_LD   = CNT_W'(EVAL_TICKS - 1);

    pe_state_e        state_q, state_d;
    logic             load;
    logic [CNT_W-1:0] load_val;
    logic [CNT_W-1:0] cnt;
    logic             last;
    logic [IDX_W-1:0] sel_clamped;
    logic [IDX_W-1:0] sel_q;
    logic [WAIT_W-1:0] wait_q;
    logic             take_cfg;
    logic [CNT_W-1:0] eval_idx;
    pe_out_t          outs;

    pe_phase_timer #(.CNT_W(CNT_W)) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (load),
        .load_val_i (load_val),
        .cnt_o      (cnt),
        .last_o     (last)
    );

    pe_sel_clamp #(.IN_W(SEL_W), .OUT_W(IDX_W), .LIMIT(EVAL_TICKS - 1)) u_clamp (
        .sel_i (cap_sel_i),
        .sel_o (sel_clamped)
    );

    // Configuration is taken only on the edge that enters INIT.
    assign take_cfg = load && (state_d == ST_INIT);

    pe_cfg_latch #(.WAIT_W(WAIT_W), .IDX_W(IDX_W)) u_cfg (
        .clk    (clk),
        .rst_n  (rst_n),
        .take_i (take_cfg),
        .wait_i (wait_cnt_i),
        .idx_i  (sel_clamped),
        .wait_o (wait_q),
        .idx_o  (sel_q)
    );

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_STOP;
        else        state_q <= state_d;
    end

    // Next-state and phase-timer load.
    always_comb begin
        state_d  = state_q;
        load     = 1'b0;
        load_val = '0;
        unique case (state_q)
            ST_STOP: begin
                if (run_i) begin
                    state_d  = ST_INIT;
                    load     = 1'b1;
                    load_val = INIT_LD;
                end
            end
            ST_INIT: begin
                if (last) begin
                    state_d  = ST_PRE;
                    load     = 1'b1;
                    load_val = PRE_LD;
                end
            end
            ST_PRE: begin
                if (last) begin
                    state_d  = ST_SETTLE;
                    load     = 1'b1;
                    load_val = SETTLE_LD;
                end
            end
            ST_SETTLE: begin
                if (last) begin
                    state_d  = ST_EVAL;
                    load     = 1'b1;
                    load_val = EVAL_LD;
                end
            end
            ST_EVAL: begin
                if (last) begin
                    state_d  = ST_WAIT;
                    load     = 1'b1;
                    load_val = wait_q;
                end
            end
            ST_WAIT: begin
                if (last) begin
                    if (run_i) begin
                        state_d  = ST_INIT;
                        load     = 1'b1;
                        load_val = INIT_LD;
                    end else begin
                        state_d  = ST_STOP;
                    end
                end
            end
            default: state_d = ST_STOP;
        endcase
    end

    // Output decode.
    always_comb begin
        eval_idx     = EVAL_LD - cnt;
        outs.init    = (state_q == ST_INIT);
        outs.pre     = (state_q == ST_PRE);
        outs.start_n = (state_q != ST_EVAL);
        outs.cap     = (state_q == ST_EVAL) &&
                       (eval_idx == {{(CNT_W-IDX_W){1'b0}}, sel_q});
        outs.done    = (state_q == ST_WAIT) && last;
    end

    assign init_o       = outs.init;
    assign precharge_o  = outs.pre;
    assign start_n_o    = outs.start_n;
    assign capture_o    = outs.cap;
    assign cycle_done_o = outs.done;

    // R3: precharge begins on the tick after the init tick.
    a_r3_pre_after_init: assert property (@(posedge clk) disable iff (!rst_n)
        init_o |=> precharge_o);

    // R4: the last settle tick is followed by evaluation.
    a_r4_settle_to_eval: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SETTLE && last) |=> !start_n_o);

    // R6: the strobe only occurs while evaluation is active.
    a_r6_cap_in_eval: assert property (@(posedge clk) disable iff (!rst_n)
        capture_o |-> !start_n_o);

    // R2: the timed phases never overlap.
    a_r2_phases_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({init_o, precharge_o, !start_n_o, cycle_done_o}));

    // R12: back-to-back cycles with no gap.
    a_r12_back_to_back: assert property (@(posedge clk) disable iff (!rst_n)
        (cycle_done_o && run_i) |=> init_o);

    // R9: stopping leaves every output idle.
    a_r9_stop_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (cycle_done_o && !run_i) |=> (!init_o && !precharge_o && start_n_o && !capture_o));

    // R8: the done pulse lasts one tick.
    a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        cycle_done_o |=> !cycle_done_o);

    // R11: configuration stays fixed away from cycle entry.
    a_r11_cfg_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_STOP && !init_o) |-> $stable(wait_q));

endmodule

// File: tb/tb_pe_cycle_seq.sv
module tb_pe_cycle_seq;

    typedef struct {
        logic [4:0] v;
        string      tag;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       run_i = 1'b0;
    logic [7:0] wait_cnt_i = '0;
    logic [2:0] cap_sel_i = '0;
    logic       init_o, precharge_o, start_n_o, capture_o, cycle_done_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;
    exp_t q[$];

    always #2.5 clk = ~clk;

    pe_cycle_seq dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .run_i        (run_i),
        .wait_cnt_i   (wait_cnt_i),
        .cap_sel_i    (cap_sel_i),
        .init_o       (init_o),
        .precharge_o  (precharge_o),
        .start_n_o    (start_n_o),
        .capture_o    (capture_o),
        .cycle_done_o (cycle_done_o)
    );

    function automatic logic [4:0] dut_vec();
        return {init_o, precharge_o, start_n_o, capture_o, cycle_done_o};
    endfunction

    task automatic push(input logic [4:0] v, input string tag);
        exp_t e;
        e.v = v;
        e.tag = tag;
        q.push_back(e);
    endtask

    // Vector order: {init, precharge, start_n, capture, done}
    task automatic push_cycle(input int n, input int k, input bit b2b, input bit held);
        int kc;
        kc = (k > 3) ? 3 : k;
        push(5'b10100, b2b ? "R12" : "R2");
        for (int i = 0; i < 4; i++) push(5'b01100, "R3");
        for (int i = 0; i < 8; i++) push(5'b00100, "R4");
        for (int i = 0; i < 4; i++) begin
            if (i == kc) push(5'b00010, held ? "R11" : ((k > 3) ? "R10" : "R6"));
            else         push(5'b00000, held ? "R11" : "R5");
        end
        for (int j = 0; j <= n; j++) begin
            if (j == n) push(5'b00101, held ? "R11" : "R8");
            else        push(5'b00100, held ? "R11" : "R7");
        end
    endtask

    // Called on the falling edge just before the cycle's INIT edge.
    task automatic run_cycle(input int n, input int k, input int drop_at,
                             input bit perturb, input bit b2b);
        int len;
        len = 18 + n;
        wait_cnt_i = 8'(n);
        cap_sel_i  = 3'(k);
        run_i      = 1'b1;
        push_cycle(n, k, b2b, perturb);
        for (int t = 1; t <= len; t++) begin
            @(negedge clk);
            if (perturb && t == 3) begin
                wait_cnt_i = 8'(n ^ 8'h5A);
                cap_sel_i  = 3'(k + 1);
            end
            if (drop_at != 0 && t == drop_at) run_i = 1'b0;
        end
    endtask

    task automatic stop_idle(input int m);
        run_i = 1'b0;
        wait_cnt_i = 8'h33;
        cap_sel_i  = 3'd6;
        for (int i = 0; i < m; i++) push(5'b00100, "R9");
        repeat (m) @(negedge clk);
    endtask

    // Monitor: compare each produced tick against the queue head.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                n_checks++;
                if (dut_vec() !== e.v) begin
                    n_fail++;
                    $display("FAIL %s: outputs %b expected %b at %0t", e.tag, dut_vec(), e.v, $time);
                end
            end
        end
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog: run did not complete, queue %0d expected 0", q.size());
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        n_checks++;
        if (dut_vec() !== 5'b00100) begin
            n_fail++;
            $display("FAIL R1: outputs %b expected %b in reset", dut_vec(), 5'b00100);
        end
        rst_n = 1'b1;
        wait_cnt_i = 8'hFF;
        for (int i = 0; i < 3; i++) push(5'b00100, "R1");
        repeat (3) @(negedge clk);

        run_cycle(0,   0, 0,  0, 0);
        run_cycle(2,   1, 0,  0, 1);
        run_cycle(255, 2, 0,  0, 1);
        run_cycle(4,   3, 0,  1, 1);
        run_cycle(1,   6, 10, 0, 1);
        stop_idle(6);
        run_cycle(0,   5, 18, 0, 0);
        stop_idle(3);
        run_cycle(3,   0, 0,  0, 0);
        stop_idle(2);

        while (q.size() > 0) @(negedge clk);
        finished = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

endmodule